// File: doc/BRIEF.md
# Waveform Timer Channel with Two Event-Driven Outputs

This block is one up-counting timer channel that produces two waveforms, A and B, over a single shared period. The counter advances on ticks from a selectable prescaled clock. It returns to zero on the tick where it equals the period compare value. Three events can change each output: its own compare, the period compare, and a software trigger. For each event a 2-bit action field chooses to leave the output alone, set it, clear it or toggle it. Pulse-width modulation with either polarity, 0 % or 100 % duty, and square waves all come from how those fields are programmed.

Software drives the block through a simple synchronous register port. One address strobe serves writes, and the same address selects a combinational read value. The command address starts or stops the tick source. Its trigger bit restarts the count and forces each output to its programmed trigger level. Compare values apply from the next tick after they are written.

Top module: `wave_timer_chan`

## Requirements
- R1: After a synchronous active-low reset the tick source is stopped, the counter reads 0, both outputs are low, and the mode word reads 0, so every action field is "none".
- R2: Mode bits [2:0] pick the tick source. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clocks from an internal prescaler. Values 4 to 7 give one tick per clock cycle in which `slow_tick` is high. The prescaler restarts from zero on a software trigger and advances only while the tick source runs.
- R3: On each tick the counter increments. On a tick where the counter equals the period register it returns to 0 instead, so one period is period+1 ticks.
- R4: Each action field is 2 bits: 00 none, 01 set, 10 clear, 11 toggle. The mode word holds them at these positions: A own compare [4:3], A period [6:5], A trigger [8:7], B own compare [10:9], B period [12:11], B trigger [14:13].
- R5: A tick on which the counter equals compare A applies the A own-compare action to output A. Compare B does the same for output B. A period match applies each output's period action.
- R6: When an output's own compare and the period compare match on the same tick, only the period action applies to that output.
- R7: Writing command bit 2 returns the counter to 0 and applies each output's trigger action to it. This holds whatever the tick source state is and overrides any tick in that cycle.
- R8: Command bit 0 starts the tick source and bit 1 stops it. If both are written together, stop wins. While stopped, the counter and both outputs hold.
- R9: An output whose compare and period actions are both none keeps the level from its last trigger indefinitely. This gives constant low or constant high.
- R10: Register addresses are 0 mode, 1 compare A, 2 compare B, 3 period, 4 command (reads 0), and 5 counter (read only). Compare and period writes are used from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulses of the slow time base, synchronous to clk |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for write and read |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `addr` |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |

## Verification
The assertions check the following on every cycle:
- counter stepping and wrap on ticks;
- restart on a trigger;
- holding of counter and outputs while stopped;
- the period action taking effect for set, clear and toggle, whether or not an own compare matches at the same tick.

Only the bench scenarios show that whole waveforms have the right period and duty for each prescaler choice and for the slow time base. The same holds for both polarities, for immediate compare rewrites, and for constant levels held from a trigger. The behavioural model in the bench follows every clock, so each divider setting and each action code is compared cycle by cycle.

// File: rtl/wtc_pkg.sv
// Package: shared types, register map and mode-word layout for the
// waveform timer channel. Assumes a mode word of 15 bits.
package wtc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    localparam int MODE_W = 15;
    localparam int PRE_W  = 7;   // prescaler width for the /128 setting

    // mode word layout
    localparam int SEL_LSB  = 0;
    localparam int SEL_W    = 3;
    localparam int A_CMP_L  = 3;
    localparam int A_PER_L  = 5;
    localparam int A_TRG_L  = 7;
    localparam int B_CMP_L  = 9;
    localparam int B_PER_L  = 11;
    localparam int B_TRG_L  = 13;

    // register addresses
    localparam logic [2:0] ADR_MODE = 3'd0;
    localparam logic [2:0] ADR_CMPA = 3'd1;
    localparam logic [2:0] ADR_CMPB = 3'd2;
    localparam logic [2:0] ADR_PER  = 3'd3;
    localparam logic [2:0] ADR_CMD  = 3'd4;
    localparam logic [2:0] ADR_CNT  = 3'd5;

    // command bits
    localparam int CMD_RUN  = 0;
    localparam int CMD_STOP = 1;
    localparam int CMD_TRIG = 2;

    // Next output level after applying one action.
    function automatic logic apply_act(input logic cur, input act_e act);
        case (act)
            ACT_SET: apply_act = 1'b1;
            ACT_CLR: apply_act = 1'b0;
            ACT_TOG: apply_act = ~cur;
            default: apply_act = cur;
        endcase
    endfunction

endpackage

// File: rtl/wtc_prescaler.sv
// Tick generator: a free-running prescaler that yields one tick every
// 2, 8, 32 or 128 clocks, or passes the slow time base through.
// Assumes slow_tick is already synchronous to clk.
module wtc_prescaler
    import wtc_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             slow_tick,
    output logic             tick
);

    logic [W-1:0] pre_q;
    logic         sel_hit;

    // Advance the prescaler while running; restart clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (run)     pre_q <= pre_q + 1'b1;
    end

    // Decode the selected divider: tick when the low bits are all ones.
    always_comb begin
        case (sel)
            3'd0:    sel_hit = pre_q[0];
            3'd1:    sel_hit = &pre_q[2:0];
            3'd2:    sel_hit = &pre_q[4:0];
            3'd3:    sel_hit = &pre_q[W-1:0];
            default: sel_hit = slow_tick;
        endcase
    end

    assign tick = run && sel_hit;

endmodule

// File: rtl/wtc_counter.sv
// Up counter with period wrap and equality detection against the period
// and against each output's own compare value. Hits are tick-qualified.
module wtc_counter #(
    parameter int CNT_W = 16,
    parameter int N_OUT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        restart,
    input  logic                        tick,
    input  logic [CNT_W-1:0]            per,
    input  logic [N_OUT-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]            cnt,
    output logic                        hit_per,
    output logic [N_OUT-1:0]            hit_cmp
);

    assign hit_per = tick && (cnt == per);

    // One equality comparator per output.
    for (genvar i = 0; i < N_OUT; i++) begin : g_cmp
        assign hit_cmp[i] = tick && (cnt == cmp[i]);
    end

    // Count ticks, wrap on the period match, restart on trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (hit_per) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wtc_wave_out.sv
// One output level register. The trigger action comes first, then the
// period action, then the own-compare action. Assumes hits are tick-qualified.
module wtc_wave_out
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic hit_cmp,
    input  logic hit_per,
    input  act_e act_cmp,
    input  act_e act_per,
    input  act_e act_trg,
    output logic wave
);

    // Apply the highest-priority event of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       wave <= 1'b0;
        else if (restart) wave <= apply_act(wave, act_trg);
        else if (hit_per) wave <= apply_act(wave, act_per);
        else if (hit_cmp) wave <= apply_act(wave, act_cmp);
    end

endmodule

// File: rtl/wave_timer_chan.sv
// Waveform timer channel top: register file, command decode, read mux
// and the two output generators. Assumes CNT_W >= 16, so that the mode
// word fits in the data port.
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             wave_a,
    output logic             wave_b
);

    localparam int N_OUT = 2;

    logic [MODE_W-1:0]           mode_q;
    logic [N_OUT-1:0][CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0]            per_q;
    logic                        run_q;
    logic                        cmd_wr;
    logic                        sw_fire;
    logic                        tick;
    logic [CNT_W-1:0]            cnt;
    logic                        hit_per;
    logic [N_OUT-1:0]            hit_cmp;
    logic [N_OUT-1:0]            wave;
    logic [N_OUT-1:0][1:0]       act_per_v;

    assign cmd_wr  = wr_en && (addr == ADR_CMD);
    assign sw_fire = cmd_wr && wr_data[CMD_TRIG];

    // Register writes: mode, compares and period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            cmp_q  <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_MODE: mode_q   <= wr_data[MODE_W-1:0];
                ADR_CMPA: cmp_q[0] <= wr_data;
                ADR_CMPB: cmp_q[1] <= wr_data;
                ADR_PER:  per_q    <= wr_data;
                default:  ;
            endcase
        end
    end

    // Run flag: stop wins over start when both are written.
    always_ff @(posedge clk) begin
        if (!rst_n)                       run_q <= 1'b0;
        else if (cmd_wr && wr_data[CMD_STOP]) run_q <= 1'b0;
        else if (cmd_wr && wr_data[CMD_RUN])  run_q <= 1'b1;
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (addr)
            ADR_MODE: rd_data[MODE_W-1:0] = mode_q;
            ADR_CMPA: rd_data = cmp_q[0];
            ADR_CMPB: rd_data = cmp_q[1];
            ADR_PER:  rd_data = per_q;
            ADR_CNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end

    wtc_prescaler #(.W(PRE_W)) i_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .restart   (sw_fire),
        .sel       (mode_q[SEL_LSB +: SEL_W]),
        .slow_tick (slow_tick),
        .tick      (tick)
    );

    wtc_counter #(.CNT_W(CNT_W), .N_OUT(N_OUT)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sw_fire),
        .tick    (tick),
        .per     (per_q),
        .cmp     (cmp_q),
        .cnt     (cnt),
        .hit_per (hit_per),
        .hit_cmp (hit_cmp)
    );

    // One generator per output; each picks its fields out of the mode word.
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        localparam int CL = (i == 0) ? A_CMP_L : B_CMP_L;
        localparam int PL = (i == 0) ? A_PER_L : B_PER_L;
        localparam int TL = (i == 0) ? A_TRG_L : B_TRG_L;

        assign act_per_v[i] = mode_q[PL +: 2];

        wtc_wave_out i_wave (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (sw_fire),
            .hit_cmp (hit_cmp[i]),
            .hit_per (hit_per),
            .act_cmp (act_e'(mode_q[CL +: 2])),
            .act_per (act_e'(mode_q[PL +: 2])),
            .act_trg (act_e'(mode_q[TL +: 2])),
            .wave    (wave[i])
        );
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];

endmodule

// File: rtl/wtc_chk.sv
// Checker for the waveform timer channel, attached by bind. Relates the
// counter, run flag, restart and tick hits to the output levels.
module wtc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             hit_per,
    input logic [1:0]       wave,
    input logic [1:0][1:0]  act_per
);

    // R3: a period match returns the counter to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_per && !restart) |=> (cnt == '0));

    // R3: a plain tick steps the counter by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit_per && !restart) |=> (cnt == $past(cnt) + 1'b1));

    // R7: a trigger restarts the count
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R8: a stopped channel holds counter and outputs
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(cnt) && $stable(wave)));

    // R2: no tick and no trigger means the counter holds
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));

    for (genvar i = 0; i < 2; i++) begin : g_o
        // R6: the period action wins even when the own compare also matches
        a_r6_per_set: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_per && !restart && act_per[i] == 2'b01) |=> wave[i]);
        a_r6_per_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_per && !restart && act_per[i] == 2'b10) |=> !wave[i]);
        // R4: toggle inverts the level
        a_r4_per_tog: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_per && !restart && act_per[i] == 2'b11) |=> (wave[i] != $past(wave[i])));
    end

endmodule

bind wave_timer_chan wtc_chk #(.CNT_W(CNT_W)) i_wtc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sw_fire),
    .tick    (tick),
    .run     (run_q),
    .cnt     (cnt),
    .hit_per (hit_per),
    .wave    (wave),
    .act_per (act_per_v)
);

// File: tb/test_wave_timer_chan.sv
// Bench: behavioural per-clock model of the channel, compared every cycle,
// plus targeted scenario checks.
module test_wave_timer_chan;

    localparam int CLK_P = 10;
    localparam int W     = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slow_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd5;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         wave_a, wave_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 0;
    bit done = 0;
    string cur_req = "R1";
    int slow_div = 0;

    // model state
    int m_pre, m_cnt, m_on, m_a, m_b, m_mode, m_ra, m_rb, m_rc;

    wave_timer_chan #(.CNT_W(W)) i_wave_timer_chan (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .wave_a(wave_a), .wave_b(wave_b)
    );

    always #(CLK_P/2) clk = ~clk;

    // slow time base: one pulse every 5 clocks
    always @(posedge clk) begin
        #1;
        slow_div = (slow_div + 1) % 5;
        slow_tick = (slow_div == 4);
    end

    function automatic int act(input int cur, input int code);
        case (code)
            1: return 1;
            2: return 0;
            3: return 1 - cur;
            default: return cur;
        endcase
    endfunction

    function automatic int fld(input int mode, input int lsb);
        return (mode >> lsb) & 3;
    endfunction

    function automatic int mk(input int sel, input int ac, input int ap, input int at,
                              input int bc, input int bp, input int bt);
        return sel | (ac << 3) | (ap << 5) | (at << 7) | (bc << 9) | (bp << 11) | (bt << 13);
    endfunction

    // reference model, stepped on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_on = 0; m_a = 0; m_b = 0;
            m_mode = 0; m_ra = 0; m_rb = 0; m_rc = 0;
        end else begin
            int sel, dv, tk, sw, hc;
            sel = m_mode & 7;
            if (sel >= 4) tk = slow_tick;
            else begin
                dv = (sel == 0) ? 2 : (sel == 1) ? 8 : (sel == 2) ? 32 : 128;
                tk = ((m_pre + 1) % dv == 0);
            end
            tk = tk && m_on;
            sw = wr_en && addr == 3'd4 && wr_data[2];
            if (sw) begin
                m_cnt = 0;
                m_a = act(m_a, fld(m_mode, 7));
                m_b = act(m_b, fld(m_mode, 13));
            end else if (tk) begin
                hc = (m_cnt == m_rc);
                if (hc) m_a = act(m_a, fld(m_mode, 5));
                else if (m_cnt == m_ra) m_a = act(m_a, fld(m_mode, 3));
                if (hc) m_b = act(m_b, fld(m_mode, 11));
                else if (m_cnt == m_rb) m_b = act(m_b, fld(m_mode, 9));
                m_cnt = hc ? 0 : (m_cnt + 1) & 16'hFFFF;
            end
            if (sw) m_pre = 0;
            else if (m_on) m_pre = (m_pre + 1) % 128;
            if (wr_en) begin
                case (addr)
                    3'd0: m_mode = int'(wr_data) & 16'h7FFF;
                    3'd1: m_ra = int'(wr_data);
                    3'd2: m_rb = int'(wr_data);
                    3'd3: m_rc = int'(wr_data);
                    3'd4: begin
                        if (wr_data[1]) m_on = 0;
                        else if (wr_data[0]) m_on = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rd();
        case (addr)
            3'd0: return m_mode;
            3'd1: return m_ra;
            3'd2: return m_rb;
            3'd3: return m_rc;
            3'd5: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            n_cmp++;
            if (int'(wave_a) != m_a || int'(wave_b) != m_b || int'(rd_data) != exp_rd()) begin
                n_bad++;
                $display("FAIL %s cycle compare @%0t: a=%0d b=%0d rd=%0d expected a=%0d b=%0d rd=%0d",
                         cur_req, $time, wave_a, wave_b, rd_data, m_a, m_b, exp_rd());
            end
        end
    end

    task automatic chk(input string tag, input int got, input int expv);
        n_cmp++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; addr = 3'(a); wr_data = W'(d);
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 3'd5; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int c1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 counter", int'(rd_data), 0);
        chk("R1 wave_a", int'(wave_a), 0);
        chk("R1 wave_b", int'(wave_b), 0);
        @(posedge clk); #1;
        addr = 3'd0; @(negedge clk);
        chk("R1 mode", int'(rd_data), 0);
        @(posedge clk); #1 addr = 3'd5;
        // R1: running with all actions none leaves outputs low
        wr(4, 1); idle(30);
        @(negedge clk); chk("R1 idle wave_a", int'(wave_a), 0);
        @(posedge clk); #1;

        // R10 register map and readback
        cur_req = "R10";
        wr(4, 2);
        wr(1, 3); wr(2, 6); wr(3, 9);
        addr = 3'd3; @(negedge clk); chk("R10 period read", int'(rd_data), 9);
        @(posedge clk); #1 addr = 3'd4; @(negedge clk); chk("R10 cmd reads 0", int'(rd_data), 0);
        @(posedge clk); #1 addr = 3'd5;

        // R5 normal A (cmp clear, period set, trig set), inverted B; /2
        cur_req = "R5";
        wr(0, mk(0, 2, 1, 1, 1, 2, 2));
        wr(4, 5);
        idle(200);
        // R2 the other dividers
        cur_req = "R2";
        wr(0, mk(1, 2, 1, 1, 1, 2, 2)); wr(4, 5); idle(260);
        wr(0, mk(2, 2, 1, 1, 1, 2, 2)); wr(4, 5); idle(1000);
        wr(0, mk(3, 2, 1, 1, 1, 2, 2)); wr(4, 5); idle(3900);
        wr(0, mk(4, 2, 1, 1, 1, 2, 2)); wr(4, 5); idle(300);

        // R10 immediate compare and period rewrite while running
        cur_req = "R10";
        wr(0, mk(0, 2, 1, 1, 1, 2, 2)); wr(4, 5);
        idle(7); wr(1, 7); wr(3, 12); idle(150);

        // R3 wrap value visible at period boundary
        cur_req = "R3";
        wr(3, 4); wr(4, 5); idle(60);

        // R6 compare equals period: period action wins
        cur_req = "R6";
        wr(1, 4); wr(2, 4);
        wr(0, mk(0, 2, 1, 2, 1, 2, 1)); wr(4, 5);
        idle(60);
        @(negedge clk); chk("R6 wave_a stays set", int'(wave_a), 1);
        chk("R6 wave_b stays clear", int'(wave_b), 0);
        @(posedge clk); #1;

        // R4 toggle on period, toggle on own compare
        cur_req = "R4";
        wr(1, 1); wr(2, 2);
        wr(0, mk(0, 0, 3, 2, 3, 0, 1)); wr(4, 5); idle(120);

        // R9 constant levels from the trigger
        cur_req = "R9";
        wr(0, mk(0, 0, 0, 1, 0, 0, 2)); wr(4, 5); idle(100);
        @(negedge clk); chk("R9 wave_a high", int'(wave_a), 1);
        chk("R9 wave_b low", int'(wave_b), 0);
        @(posedge clk); #1;

        // R7 trigger while stopped restarts and applies trigger levels
        cur_req = "R7";
        wr(4, 2);
        wr(0, mk(0, 2, 1, 2, 1, 2, 1));
        wr(4, 4); @(negedge clk);
        chk("R7 counter zero", int'(rd_data), 0);
        chk("R7 wave_a", int'(wave_a), 0);
        chk("R7 wave_b", int'(wave_b), 1);
        @(posedge clk); #1;

        // R8 stop holds; start and stop together stops
        cur_req = "R8";
        wr(0, mk(0, 2, 1, 1, 1, 2, 2)); wr(3, 20); wr(4, 5); idle(23);
        wr(4, 2); @(negedge clk); c1 = int'(rd_data);
        idle(40); @(negedge clk); chk("R8 counter held", int'(rd_data), c1);
        @(posedge clk); #1;
        wr(4, 1); idle(10);
        wr(4, 3); @(negedge clk); c1 = int'(rd_data);
        idle(30); @(negedge clk); chk("R8 both bits stop", int'(rd_data), c1);
        @(posedge clk); #1;

        finish_run();
    end

endmodule